// File: doc/BRIEF.md
# Delay Line Stage-Count Sensor

This block turns a one-cycle snapshot of a delay chain into a number. The chain is a series of inverting stages, and the clock itself drives its input. Every falling clock edge launches a transition into the chain. On the next rising edge, half a period later, every stage output is sampled in parallel. The block receives that snapshot as a tap vector and reports how many stages, counted from the input end, the transition has crossed. A slower chain gives a smaller number, for example at a lower supply voltage or a higher die temperature. A supply controller can compare the number against a threshold to detect a shrinking timing margin. The physical chain lies outside this block; the tap vector is its boundary.

Inside the block, a capture register holds the snapshot. A fixed polarity mask then flips every odd-indexed tap, which turns the alternating inverter levels into a thermometer code: 1 marks a stage the edge has crossed, 0 marks one it has not reached. A two-level detector finds the first 0 from the input end, and the result goes to a registered output. A small controller gates the valid strobe. It has three states. S_FLUSH is the state entered on reset; the capture register holds no real sample yet. S_FILL follows: the capture register now holds the first real sample. S_TRACK comes last: the output holds a reading of a real sample. The only transitions are S_FLUSH→S_FILL and S_FILL→S_TRACK, one on each rising edge. S_TRACK→S_TRACK repeats for as long as reset stays low. Reset sends the controller from any state back to S_FLUSH.

Top module: `dly_depth_sensor`

## Requirements
- R1: While the synchronous reset is high at a rising edge, the capture register, `depth_o` and `depth_vld_o` are cleared to zero at that edge.
- R2: A tap vector sampled at rising edge n appears on `depth_o` after rising edge n+1. After reset is released, `depth_vld_o` first rises after the second rising edge. While `depth_vld_o` is low, `depth_o` is zero.
- R3: Polarity: a tap at an even index (0, 2, 4…) counts as switched when it is 1. A tap at an odd index counts as switched when it is 0.
- R4: The reading is the index of the first unswitched stage, counted from index 0. If no stage has switched, the reading is 0. If all NUM_STAGES (default 128) stages have switched, the reading is NUM_STAGES. The reading is an 8-bit count at the default size.
- R5: Bubbles: taps above the first unswitched stage have no effect on the reading.
- R6: While valid, the reading is refreshed on every rising edge from the newest sample, with no holding or averaging.
- R7: A reset raised in S_TRACK drops `depth_vld_o` and clears `depth_o` at the edge where reset is sampled. Afterwards the controller runs through S_FLUSH and S_FILL again.
- R8: Once `depth_vld_o` is high, it stays high until reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; its falling edge launches the chain, its rising edge samples |
| rst_i | input | 1 | Synchronous reset, active high |
| taps_i | input | NUM_STAGES | Parallel stage outputs of the delay chain |
| depth_o | output | COUNT_W | Registered stage-count reading |
| depth_vld_o | output | 1 | High while depth_o holds a reading of a real sample |

## Verification
The assertions take the tap vector to be stable around each rising edge, and they allow any bit pattern, including bubbles and fully switched or fully unswitched chains. They also assume that reset is held low after its release, apart from deliberate mid-run pulses. The stimulus changes taps and reset only on falling edges. It sweeps every depth from 0 to the full chain length, both with clean patterns and with random bits above the first unswitched stage. It also applies raw all-ones and all-zeros vectors. It pulses reset in the middle of a run.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // Controller states: flush the capture stage, fill it, then track.
    typedef enum logic [1:0] {
        S_FLUSH = 2'd0,
        S_FILL  = 2'd1,
        S_TRACK = 2'd2
    } sense_state_e;

    // Level that a stage shows once the launched edge has crossed it.
    function automatic logic switched_level(input int idx);
        return (idx % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

endpackage

// File: rtl/dds_tap_capture.sv
module dds_tap_capture #(
    parameter int NUM_STAGES = 128
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [NUM_STAGES-1:0] taps_i,
    output logic [NUM_STAGES-1:0] snap_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            snap_o <= '0;
        end else begin
            snap_o <= taps_i;
        end
    end

endmodule

// File: rtl/dds_polarity_fix.sv
module dds_polarity_fix #(
    parameter int NUM_STAGES = 128
) (
    input  logic [NUM_STAGES-1:0] raw_i,
    output logic [NUM_STAGES-1:0] therm_o
);
    import dds_pkg::*;

    // Every stage maps to 1 once crossed and to 0 before.
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        localparam logic FLIP = ~switched_level(i);
        assign therm_o[i] = raw_i[i] ^ FLIP;
    end

endmodule

// File: rtl/dds_first_gap.sv
module dds_first_gap #(
    parameter int NUM_STAGES = 128,
    parameter int GRP        = 8,
    parameter int COUNT_W    = $clog2(NUM_STAGES + 1)
) (
    input  logic [NUM_STAGES-1:0] therm_i,
    output logic [COUNT_W-1:0]    gap_o
);
    localparam int NGRP  = (NUM_STAGES + GRP - 1) / GRP;
    localparam int PAD_W = NGRP * GRP;
    localparam int LW    = (GRP > 1) ? $clog2(GRP) : 1;

    // Padding bits read as unswitched, so a full chain lands on NUM_STAGES.
    logic [PAD_W-1:0]   padded;
    logic [NGRP-1:0]    grp_full;
    logic [NGRP*LW-1:0] grp_loc;

    assign padded = PAD_W'(therm_i);

    // Level one: first zero inside each group.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic          full_g;
        logic [LW-1:0] loc_g;
        always_comb begin
            full_g = 1'b1;
            loc_g  = '0;
            for (int b = GRP - 1; b >= 0; b--) begin
                if (!padded[g*GRP + b]) begin
                    full_g = 1'b0;
                    loc_g  = LW'(b);
                end
            end
        end
        assign grp_full[g]          = full_g;
        assign grp_loc[g*LW +: LW]  = loc_g;
    end

    // Level two: the lowest group that is not full.
    always_comb begin
        gap_o = COUNT_W'(NUM_STAGES);
        for (int g = NGRP - 1; g >= 0; g--) begin
            if (!grp_full[g]) begin
                gap_o = COUNT_W'(g * GRP) + COUNT_W'(grp_loc[g*LW +: LW]);
            end
        end
    end

endmodule

// File: rtl/dly_depth_sensor.sv
module dly_depth_sensor #(
    parameter int NUM_STAGES = 128,
    parameter int GRP        = 8,
    localparam int COUNT_W   = $clog2(NUM_STAGES + 1)
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [NUM_STAGES-1:0] taps_i,
    output logic [COUNT_W-1:0]    depth_o,
    output logic                  depth_vld_o
);
    import dds_pkg::*;

    sense_state_e              state_q, state_d;
    logic [NUM_STAGES-1:0]     snap;
    logic [NUM_STAGES-1:0]     therm;
    logic [COUNT_W-1:0]        gap;

    dds_tap_capture #(.NUM_STAGES(NUM_STAGES)) u_capture (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .taps_i (taps_i),
        .snap_o (snap)
    );

    dds_polarity_fix #(.NUM_STAGES(NUM_STAGES)) u_polarity (
        .raw_i   (snap),
        .therm_o (therm)
    );

    dds_first_gap #(.NUM_STAGES(NUM_STAGES), .GRP(GRP), .COUNT_W(COUNT_W)) u_gap (
        .therm_i (therm),
        .gap_o   (gap)
    );

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= S_FLUSH;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FLUSH: state_d = S_FILL;
            S_FILL:  state_d = S_TRACK;
            S_TRACK: state_d = S_TRACK;
            default: state_d = S_FLUSH;
        endcase
    end

    // Output register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            depth_o     <= '0;
            depth_vld_o <= 1'b0;
        end else begin
            unique case (state_q)
                S_FLUSH: begin
                    depth_o     <= '0;
                    depth_vld_o <= 1'b0;
                end
                S_FILL, S_TRACK: begin
                    depth_o     <= gap;
                    depth_vld_o <= 1'b1;
                end
                default: begin
                    depth_o     <= '0;
                    depth_vld_o <= 1'b0;
                end
            endcase
        end
    end

    AST_RST_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (depth_o == '0 && !depth_vld_o)); // R1

    AST_INVALID_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !depth_vld_o |-> depth_o == '0); // R2

    AST_VLD_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(depth_vld_o) |-> $past(state_q) == S_FILL); // R2

    AST_DEPTH_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        depth_o <= COUNT_W'(NUM_STAGES)); // R4

    AST_GAP_UNSWITCHED: assert property (@(posedge clk_i) disable iff (rst_i)
        (gap < COUNT_W'(NUM_STAGES)) |-> !therm[gap]); // R4

    AST_BELOW_GAP_SWITCHED: assert property (@(posedge clk_i) disable iff (rst_i)
        (gap != '0) |-> therm[gap - COUNT_W'(1)]); // R5

    AST_VLD_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        depth_vld_o |=> depth_vld_o); // R8

endmodule

// File: tb/dly_depth_sensor_tb.sv
module dly_depth_sensor_tb;
    localparam int N  = 128;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  taps = '0;
    logic [CW-1:0] depth;
    logic          vld;

    int n_chk  = 0;
    int n_fail = 0;

    // two-deep expectation pipe: value and validity
    int   e1 = 0, e2 = 0;
    logic v1 = 1'b0, v2 = 1'b0;
    string t1 = "R1", t2 = "R1";

    always #5ns clk = ~clk;

    dly_depth_sensor #(.NUM_STAGES(N)) u_dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .taps_i      (taps),
        .depth_o     (depth),
        .depth_vld_o (vld)
    );

    function automatic logic sw_lvl(int i);
        return (i % 2 == 0);
    endfunction

    // first unswitched stage from the input end (R3, R4)
    function automatic int ref_depth(logic [N-1:0] t);
        for (int i = 0; i < N; i++) if (t[i] != sw_lvl(i)) return i;
        return N;
    endfunction

    function automatic logic [N-1:0] build(int d, bit noisy);
        logic [N-1:0] t;
        for (int i = 0; i < N; i++) begin
            if (i < d)       t[i] = sw_lvl(i);
            else if (i == d) t[i] = ~sw_lvl(i);
            else if (noisy)  t[i] = 1'($urandom_range(0, 1));
            else             t[i] = ~sw_lvl(i);
        end
        return t;
    endfunction

    // at a falling edge: check the reading due now, then drive the next input
    task automatic step(logic [N-1:0] t, logic r, string tag);
        @(negedge clk);
        n_chk++;
        if (v2) begin
            if (!(vld === 1'b1 && depth === CW'(e2))) begin
                n_fail++;
                $display("FAIL %s: depth=%0d vld=%b expected depth=%0d vld=1", t2, depth, vld, e2);
            end
        end else begin
            if (!(vld === 1'b0 && depth === '0)) begin
                n_fail++;
                $display("FAIL %s: depth=%0d vld=%b expected depth=0 vld=0", t2, depth, vld);
            end
        end
        e2 = e1; v2 = v1 & ~r; t2 = t1;
        rst = r; taps = t;
        e1 = ref_depth(t); v1 = ~r; t1 = tag;
    endtask

    initial begin
        #2_000_000ns;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: held reset
        for (int k = 0; k < 3; k++) step(build(40, 1'b0), 1'b1, "R1");
        // R2: release; first two readings invalid, then the first sample
        step(build(50, 1'b0), 1'b0, "R2");
        step(build(7, 1'b0), 1'b0, "R2");
        // R4 / R6: clean sweep over every depth, a new value each cycle
        for (int d = 0; d <= N; d++) step(build(d, 1'b0), 1'b0, "R4");
        // R5: bubbles above the first gap
        for (int d = 0; d <= N; d++) step(build(d, 1'b1), 1'b0, "R5");
        // R3: raw polarity corner vectors
        step('1, 1'b0, "R3");
        step('0, 1'b0, "R3");
        step({N{2'b01}} >> N, 1'b0, "R3");
        // R6: alternating extremes every edge
        for (int k = 0; k < 8; k++) step(build((k % 2) ? N : 0, 1'b0), 1'b0, "R6");
        // R7: mid-run reset pulse, then re-entry through flush and fill
        step(build(90, 1'b0), 1'b0, "R7");
        step(build(91, 1'b0), 1'b1, "R7");
        step(build(92, 1'b0), 1'b0, "R7");
        step(build(93, 1'b0), 1'b0, "R7");
        // R8: long stretch of random vectors while valid
        for (int k = 0; k < 64; k++) begin
            logic [N-1:0] t;
            for (int w = 0; w < N; w += 32) t[w +: 32] = $urandom;
            step(t, 1'b0, "R8");
        end
        step(build(3, 1'b0), 1'b0, "R8");
        step(build(3, 1'b0), 1'b0, "R8");
        step(build(3, 1'b0), 1'b0, "R8");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule